// File: doc/BRIEF.md
# Spread-Spectrum Current-Mode PWM Generator

This block turns a system clock into a fixed-frequency gate-drive pulse train for a current-mode switching converter. Each switching period begins with the gate going high and a one-clock cycle-start strobe. The pulse then ends at the first of three causes: the PWM comparator flag, the over-current flag, or a cap on the duty cycle at three quarters of the period. Both comparator flags are masked for a leading-edge blanking window after the start of each pulse, because switching noise there is not meaningful. The analog ramp, slope compensation, the comparators and the driver lie outside the block. They reach it only as the two flag inputs and the gate output.

To spread conducted and radiated emissions, the period length is not constant. A 4-bit maximal-length shift register advances once per period. Its state picks one of fifteen period counts, spaced evenly and symmetrically about the nominal count, so the pattern repeats every fifteen periods and the frequency swings by about 20% peak to peak. The clock frequency, the nominal switching frequency, the spread, the blanking length and the minimum pulse time are parameters. Every count is derived from them.

The controller is a four-state machine. The states are OFF_IDLE (disabled), ON_BLANK (gate high, flags masked), ON_SENSE (gate high, flags honoured) and OFF_WAIT (pulse ended, waiting for the period to finish). The transitions are named as follows:
- start: OFF_IDLE to ON_BLANK on enable.
- unmask: ON_BLANK to ON_SENSE at the end of blanking.
- trip: ON_SENSE to OFF_WAIT on a flag or the duty cap.
- wrap: ON_SENSE or OFF_WAIT to ON_BLANK at period end.
- halt: any active state to OFF_IDLE when enable drops.

Top module: `spread_pwm`

## Requirements
- R1: While reset is held, gate_o and cycle_start_o are 0 and period_o equals the nominal count NOM = CLK_HZ/SW_HZ.
- R2: While en_i is low, gate_o stays 0 and no cycle_start_o strobe occurs. Dropping en_i during a pulse forces gate_o to 0 from the next clock.
- R3: The period count is NOM + (s - 8) * STEP, with STEP = NOM * SPREAD_PCT / 1400. Here s is the state of a 4-bit shift register seeded to 4'b0001 at reset, whose next state is {s[2:0], s[3]^s[2]}. The register advances once at every period start and never resets on disable, so the sequence of period lengths repeats every 15 periods.
- R4: cycle_start_o is high for exactly the first clock of each period. period_o holds the length in clocks of the period in progress.
- R5: gate_o is high in the first clock of every period. It rises only in that clock, so there is at most one rising edge per period.
- R6: During the first BLANK_CYC clocks of a period, both pwm_trip_i and oc_trip_i are ignored.
- R7: If oc_trip_i is high at period clock t >= BLANK_CYC while the pulse is on, gate_o is 0 in that same clock. It stays 0 until the next period.
- R8: If pwm_trip_i is high at period clock t >= max(BLANK_CYC, MIN_ON - 1) while the pulse is on, gate_o is 0 from clock t + 1 to the end of the period. MIN_ON = (CLK_HZ/1000) * MIN_ON_NS / 1000000.
- R9: If no flag ends the pulse, gate_o goes low after floor(3 * period / 4) clocks.
- R10: When en_i is sampled high in OFF_IDLE, the next clock is the first clock of a period. It carries the strobe, and the period length is the next value of the R3 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable |
| pwm_trip_i | input | 1 | PWM comparator flag (sense plus ramp above control level) |
| oc_trip_i | input | 1 | Over-current comparator flag |
| gate_o | output | 1 | Gate-drive pulse |
| cycle_start_o | output | 1 | One-clock strobe at the start of each period |
| period_o | output | CW | Length in clocks of the current period |

## Verification
The hardest cases to reach are flag edges placed exactly at the blanking boundary and at the minimum-pulse boundary, together with a flag pulse that begins and ends inside the blanking window. The bench tracks the clock index since the last strobe and drives each flag as a window given by a start offset and a length. This puts trip edges on chosen clocks, such as the last blanked clock or the first sensed clock, in a period whose length it predicts from its own model of the shift register. Sixteen back-to-back periods run without a gap. The bench compares the first and the sixteenth, then checks halt and restart in the middle of the sequence to show that the spreading sequence continues across a disable.

// File: rtl/spread_pwm_pkg.sv
package spread_pwm_pkg;

    localparam int SEQ_W = 4;

    typedef enum logic [1:0] {
        OFF_IDLE = 2'd0,
        ON_BLANK = 2'd1,
        ON_SENSE = 2'd2,
        OFF_WAIT = 2'd3
    } pwm_state_e;

    function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
        return {s[SEQ_W-2:0], s[3] ^ s[2]};
    endfunction

endpackage

// File: rtl/spread_pwm_prbs.sv
module spread_pwm_prbs
    import spread_pwm_pkg::*;
#(
    parameter logic [SEQ_W-1:0] SEED = 4'b0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [SEQ_W-1:0] state_o
);

    logic [SEQ_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else if (adv_i) begin
            sr_q <= seq_step(sr_q);
        end
    end

    assign state_o = sr_q;

endmodule

// File: rtl/spread_pwm_pmap.sv
module spread_pwm_pmap
    import spread_pwm_pkg::*;
#(
    parameter int NOM  = 1000,
    parameter int STEP = 14,
    parameter int CW   = 11
) (
    input  logic [SEQ_W-1:0] state_i,
    output logic [CW-1:0]    period_o
);

    localparam int ENTRIES = 1 << SEQ_W;
    localparam int BASE    = NOM - 8 * STEP;

    logic [CW-1:0] lut [ENTRIES];

    // Entry 0 is never selected by a maximal-length sequence; it is filled
    // with the nominal count so the table holds no undefined value.
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_lut
            if (i == 0) begin : g_zero
                assign lut[i] = CW'(NOM);
            end else begin : g_step
                assign lut[i] = CW'(BASE + i * STEP);
            end
        end
    endgenerate

    assign period_o = lut[state_i];

endmodule

// File: rtl/spread_pwm_fsm.sv
module spread_pwm_fsm
    import spread_pwm_pkg::*;
#(
    parameter int NOM    = 1000,
    parameter int CW     = 11,
    parameter int BLANK  = 20,
    parameter int MIN_ON = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          pwm_trip_i,
    input  logic          oc_trip_i,
    input  logic [CW-1:0] per_next_i,
    output logic          adv_o,
    output logic          gate_o,
    output logic          cycle_start_o,
    output logic [CW-1:0] period_o
);

    localparam int BLANK_LAST = (BLANK > 0) ? BLANK - 1 : 0;
    localparam int PWM_EARLY  = (MIN_ON > 0) ? MIN_ON - 1 : 0;

    pwm_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] per_q, per_d;

    logic [CW+1:0] per_x3;
    logic [CW-1:0] max_on;
    logic          at_wrap;
    logic          at_cap;
    logic          pwm_live;
    logic          adv_d;

    // Duty cap: floor(3 * period / 4), built from a shift-add.
    assign per_x3   = {2'b00, per_q} + {1'b0, per_q, 1'b0};
    assign max_on   = per_x3[CW+1:2];
    assign at_wrap  = (cnt_q == per_q - CW'(1));
    assign at_cap   = (cnt_q == max_on - CW'(1));
    assign pwm_live = pwm_trip_i && (cnt_q >= CW'(PWM_EARLY));

    // Next-state and counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + CW'(1);
        per_d = per_q;
        adv_d = 1'b0;
        unique case (st_q)
            OFF_IDLE: begin
                cnt_d = '0;
                if (en_i) begin                       // start
                    st_d  = ON_BLANK;
                    per_d = per_next_i;
                    adv_d = 1'b1;
                end
            end
            ON_BLANK: begin
                if (!en_i) begin                      // halt
                    st_d  = OFF_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == CW'(BLANK_LAST)) begin
                    st_d = ON_SENSE;                  // unmask
                end
            end
            ON_SENSE: begin
                if (!en_i) begin                      // halt
                    st_d  = OFF_IDLE;
                    cnt_d = '0;
                end else if (at_wrap) begin           // wrap
                    st_d  = ON_BLANK;
                    cnt_d = '0;
                    per_d = per_next_i;
                    adv_d = 1'b1;
                end else if (oc_trip_i || pwm_live || at_cap) begin
                    st_d = OFF_WAIT;                  // trip
                end
            end
            OFF_WAIT: begin
                if (!en_i) begin                      // halt
                    st_d  = OFF_IDLE;
                    cnt_d = '0;
                end else if (at_wrap) begin           // wrap
                    st_d  = ON_BLANK;
                    cnt_d = '0;
                    per_d = per_next_i;
                    adv_d = 1'b1;
                end
            end
            default: begin
                st_d  = OFF_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OFF_IDLE;
            cnt_q <= '0;
            per_q <= CW'(NOM);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            per_q <= per_d;
        end
    end

    // Outputs. The over-current path is combinational so a trip cuts the
    // pulse in the clock where it is seen.
    always_comb begin
        gate_o        = 1'b0;
        cycle_start_o = 1'b0;
        unique case (st_q)
            OFF_IDLE: gate_o = 1'b0;
            ON_BLANK: gate_o = 1'b1;
            ON_SENSE: gate_o = !oc_trip_i;
            OFF_WAIT: gate_o = 1'b0;
            default:  gate_o = 1'b0;
        endcase
        cycle_start_o = (st_q != OFF_IDLE) && (cnt_q == '0);
    end

    assign adv_o    = adv_d;
    assign period_o = per_q;

endmodule

// File: rtl/spread_pwm.sv
module spread_pwm
    import spread_pwm_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int SW_HZ      = 100_000,
    parameter int SPREAD_PCT = 20,
    parameter int BLANK_CYC  = 20,
    parameter int MIN_ON_NS  = 500,
    localparam int NOM       = CLK_HZ / SW_HZ,
    localparam int STEP      = NOM * SPREAD_PCT / 1400,
    localparam int P_MAX     = NOM + 7 * STEP,
    localparam int CW        = $clog2(P_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          pwm_trip_i,
    input  logic          oc_trip_i,
    output logic          gate_o,
    output logic          cycle_start_o,
    output logic [CW-1:0] period_o
);

    localparam int MIN_ON = (CLK_HZ / 1000) * MIN_ON_NS / 1_000_000;

    logic             adv;
    logic [SEQ_W-1:0] seq_state;
    logic [CW-1:0]    per_next;

    spread_pwm_prbs #(
        .SEED (4'b0001)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .state_o (seq_state)
    );

    spread_pwm_pmap #(
        .NOM  (NOM),
        .STEP (STEP),
        .CW   (CW)
    ) u_pmap (
        .state_i  (seq_state),
        .period_o (per_next)
    );

    spread_pwm_fsm #(
        .NOM    (NOM),
        .CW     (CW),
        .BLANK  (BLANK_CYC),
        .MIN_ON (MIN_ON)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .pwm_trip_i    (pwm_trip_i),
        .oc_trip_i     (oc_trip_i),
        .per_next_i    (per_next),
        .adv_o         (adv),
        .gate_o        (gate_o),
        .cycle_start_o (cycle_start_o),
        .period_o      (period_o)
    );

endmodule

// File: rtl/spread_pwm_chk.sv
module spread_pwm_chk #(
    parameter int CW    = 11,
    parameter int BLANK = 20,
    parameter int P_MIN = 902,
    parameter int P_MAX = 1098
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic          oc_trip_i,
    input logic          gate_o,
    input logic          cycle_start_o,
    input logic [CW-1:0] period_o
);

    logic [CW:0] cyc_q;
    logic [CW:0] t_now;
    logic [CW+2:0] cap;

    assign t_now = cycle_start_o ? '0 : cyc_q;
    assign cap   = ({3'b000, period_o} * 3) >> 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (t_now != {(CW+1){1'b1}}) begin
            cyc_q <= t_now + 1'b1;
        end
    end

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!gate_o && !cycle_start_o));

    p_period_in_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(period_o) >= P_MIN) && (int'(period_o) <= P_MAX));

    p_strobe_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o);

    p_rise_only_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> cycle_start_o);

    p_start_clock_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> gate_o);

    p_oc_cuts_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_trip_i && (t_now >= (CW+1)'(BLANK))) |-> !gate_o);

    p_duty_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> ({2'b00, t_now} < cap));

endmodule

bind spread_pwm spread_pwm_chk #(
    .CW    (CW),
    .BLANK (BLANK_CYC),
    .P_MIN (NOM - 7 * STEP),
    .P_MAX (P_MAX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .oc_trip_i     (oc_trip_i),
    .gate_o        (gate_o),
    .cycle_start_o (cycle_start_o),
    .period_o      (period_o)
);

// File: tb/sim_spread_pwm.sv
module sim_spread_pwm;

    localparam int CLK_HZ  = 250_000_000;
    localparam int SW_HZ   = 1_000_000;
    localparam int SPREAD  = 20;
    localparam int BLANK   = 10;
    localparam int MINNS   = 100;
    localparam int NOM     = CLK_HZ / SW_HZ;          // 250
    localparam int STEP    = NOM * SPREAD / 1400;     // 3
    localparam int MINON   = (CLK_HZ / 1000) * MINNS / 1_000_000; // 25
    localparam int CW      = $clog2(NOM + 7 * STEP + 1);
    localparam int NV      = 16;
    localparam int NEVER   = 100000;
    localparam int LONG    = 100000;

    // {pwm_at, pwm_len, oc_at, oc_len}; offsets are clocks since the strobe.
    localparam int VEC [NV][4] = '{
        '{NEVER, 0,    NEVER, 0},    // R9 duty cap
        '{0,     LONG, NEVER, 0},    // R8 minimum pulse with flag from start
        '{NEVER, 0,    0,     LONG}, // R6 R7 oc held through blanking
        '{60,    LONG, NEVER, 0},    // R8 mid-pulse pwm trip
        '{NEVER, 0,    60,    LONG}, // R7 mid-pulse oc trip
        '{12,    LONG, NEVER, 0},    // R8 trip after blanking but before min
        '{NEVER, 0,    10,    LONG}, // R7 oc on first sensed clock
        '{NEVER, 0,    4,     5},    // R6 oc pulse inside blanking ignored
        '{2,     20,   NEVER, 0},    // R8 pwm pulse ending before min ignored
        '{100,   1,    NEVER, 0},    // R8 single-clock pwm pulse
        '{NEVER, 0,    120,   1},    // R7 single-clock oc pulse
        '{80,    LONG, 80,    LONG}, // R7 R8 oc wins same clock
        '{200,   LONG, NEVER, 0},    // R9 cap before late pwm
        '{NEVER, 0,    300,   LONG}, // R9 oc after pulse already off
        '{50,    1,    40,    1},    // R7 earlier oc wins
        '{NEVER, 0,    NEVER, 0}     // R3 repeat of first period
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b0;
    logic          pwm_trip_i = 1'b0;
    logic          oc_trip_i = 1'b0;
    logic          gate_o;
    logic          cycle_start_o;
    logic [CW-1:0] period_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [3:0] m_seq = 4'b0001;
    int  first_len = -1;

    always #2 clk = ~clk;

    spread_pwm #(
        .CLK_HZ     (CLK_HZ),
        .SW_HZ      (SW_HZ),
        .SPREAD_PCT (SPREAD),
        .BLANK_CYC  (BLANK),
        .MIN_ON_NS  (MINNS)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .pwm_trip_i    (pwm_trip_i),
        .oc_trip_i     (oc_trip_i),
        .gate_o        (gate_o),
        .cycle_start_o (cycle_start_o),
        .period_o      (period_o)
    );

    function automatic logic [3:0] m_next(input logic [3:0] s);
        return {s[2:0], s[3] ^ s[2]};
    endfunction

    function automatic int per_of(input logic [3:0] s);
        return NOM + (int'(s) - 8) * STEP;
    endfunction

    function automatic int exp_width(input int pa, input int pl, input int oa,
                                     input int ol, input int per);
        int cap_w;
        cap_w = (per * 3) / 4;
        for (int t = 0; t < cap_w; t++) begin
            if (t >= BLANK && t >= oa && t < oa + ol) return t;
            if (t >= BLANK && t >= MINON - 1 && t >= pa && t < pa + pl) return t + 1;
        end
        return cap_w;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Entered at a falling edge on which cycle_start_o is high; returns at
    // the falling edge of the next strobe.
    task automatic run_period(input int pa, input int pl, input int oa, input int ol,
                              output int width, output int rises, output int len,
                              output int per_seen);
        int  t;
        logic prev;
        t = 0; width = 0; rises = 0; prev = 1'b0;
        per_seen = int'(period_o);
        do begin
            pwm_trip_i = (t >= pa) && (t < pa + pl);
            oc_trip_i  = (t >= oa) && (t < oa + ol);
            #1;
            if (gate_o) width++;
            if (gate_o && !prev) rises++;
            prev = gate_o;
            if (int'(period_o) != per_seen) per_seen = -1;
            @(negedge clk);
            t++;
        end while (!cycle_start_o && t < 4 * NOM);
        len = t;
        pwm_trip_i = 1'b0;
        oc_trip_i  = 1'b0;
    endtask

    initial begin
        int w, r, l, p, ep;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", "gate in reset", int'(gate_o), 0);
        check("R1", "strobe in reset", int'(cycle_start_o), 0);
        check("R1", "period in reset", int'(period_o), NOM);
        rst_n = 1'b1;

        // R2: disabled, flags toggling, nothing happens
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                pwm_trip_i = i[0];
                oc_trip_i  = i[1];
                #1;
                if (gate_o || cycle_start_o) hi++;
            end
            pwm_trip_i = 1'b0;
            oc_trip_i  = 1'b0;
            check("R2", "activity while disabled", hi, 0);
        end

        // R10: enable starts a period on the next clock
        @(negedge clk);
        en_i = 1'b1;
        @(negedge clk);
        check("R10", "strobe after enable", int'(cycle_start_o), 1);
        check("R10", "gate after enable", int'(gate_o), 1);

        // Vector table: consecutive periods
        for (int v = 0; v < NV; v++) begin
            ep = per_of(m_seq);
            m_seq = m_next(m_seq);
            run_period(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], w, r, l, p);
            check("R3", $sformatf("period length v%0d", v), l, ep);
            check("R4", $sformatf("period_o v%0d", v), p, ep);
            check("R5", $sformatf("rising edges v%0d", v), r, 1);
            check("R6 R7 R8 R9", $sformatf("pulse width v%0d", v), w,
                  exp_width(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], ep));
            if (v == 0) first_len = l;
            if (v == 15) check("R3", "15-period repeat", l, first_len);
        end

        // R2: halt during blanking; we sit on a strobe edge here
        ep = per_of(m_seq);
        m_seq = m_next(m_seq);
        check("R4", "period_o at halted start", int'(period_o), ep);
        en_i = 1'b0;
        @(negedge clk);
        #1;
        check("R2", "gate after halt", int'(gate_o), 0);
        check("R2", "strobe after halt", int'(cycle_start_o), 0);
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                oc_trip_i = 1'b0;
                pwm_trip_i = 1'b0;
                #1;
                if (gate_o || cycle_start_o) hi++;
            end
            check("R2", "activity after halt", hi, 0);
        end

        // R10 / R3: restart continues the sequence
        en_i = 1'b1;
        @(negedge clk);
        check("R10", "strobe after restart", int'(cycle_start_o), 1);
        ep = per_of(m_seq);
        m_seq = m_next(m_seq);
        run_period(NEVER, 0, NEVER, 0, w, r, l, p);
        check("R3", "period after restart", l, ep);
        check("R9", "width after restart", w, (ep * 3) / 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule